// File: doc/BRIEF.md
# TLB Control and Replacement Logic

This block is the control register and way-selection logic for a four-way set-associative translation buffer with 32 sets. Software writes a 32-bit register that holds the translation enable, the set-index hashing choice, the single/multiple address-space mode and a 2-bit replacement counter. Writing a 1 to the flush field makes the block emit a one-cycle strobe that the translation buffer uses to clear every valid bit. The flush field is a command and is never stored.

On each access the block forms the 5-bit set index from virtual address bits 16..12. When hashing is enabled, those bits are XORed with the low five bits of the address-space identifier. When the translation buffer reports an exception, the replacement counter is updated. On a miss it points at the lowest-numbered empty way of the faulting set, or it advances round-robin when all four ways are occupied. On any other fault it is loaded with the number of the way that faulted. The entry storage and the tag compare lie outside the block and reach it as input signals.

Top module: `tlb_ctrl_top`

## Requirements
- R1: After synchronous reset, rd_data reads 0, flush_pulse is 0 and xlat_on, idx_hash and single_space are 0.
- R2: A write stores bit 0 (translation enable, output xlat_on), bit 1 (index hashing, output idx_hash), bit 8 (1 = single space, output single_space) and bits 5:4 (replacement counter). All of these read back at the same positions.
- R3: Bits 3, 7:6 and 31:9 always read as 0, whatever value was written to them.
- R4: A write with bit 2 set drives flush_pulse high for exactly the one cycle that follows the write. A write with bit 2 clear produces no pulse. Bit 2 always reads as 0.
- R5: With idx_hash at 0, set_idx equals va[16:12].
- R6: With idx_hash at 1, set_idx equals va[16:12] XOR asid[4:0].
- R7: On miss_evt, when set_valid is 4'b1111, the counter increments by 1 modulo 4.
- R8: On miss_evt, when any bit of set_valid (bit n = way n) is 0, the counter is loaded with the lowest n whose valid bit is 0.
- R9: On other_evt without miss_evt, the counter is loaded with fault_way.
- R10: When a register write and an exception event occur in the same cycle, the event decides the counter, and the write still updates the other fields.
- R11: When miss_evt and other_evt are both asserted, the miss rule applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value |
| miss_evt | input | 1 | One-cycle TLB miss exception strobe |
| other_evt | input | 1 | One-cycle strobe for any other MMU exception |
| set_valid | input | 4 | Valid bits of the four ways at the faulting set |
| fault_way | input | 2 | Way that caused a non-miss exception |
| va | input | 32 | Virtual address |
| asid | input | 8 | Address-space identifier |
| set_idx | output | 5 | TLB set index |
| xlat_on | output | 1 | Translation enabled |
| idx_hash | output | 1 | Index hashing with ASID enabled |
| single_space | output | 1 | Single virtual space mode |
| flush_pulse | output | 1 | One-cycle strobe that clears all TLB valid bits |

## Verification
The bench builds the block with its default parameters: four ways, a 2-bit counter, 32 sets and a page shift of 12. These values put every priority position of the empty-way search within reach, along with the counter wrap from 3 to 0. Directed valid patterns place the first empty way at each of the four positions. Same-cycle collisions cover a register write against a hardware event and a miss against another fault.

// File: rtl/tlb_ctl_pkg.sv
package tlb_ctl_pkg;
    localparam int WAYS       = 4;
    localparam int CNT_W      = $clog2(WAYS);
    localparam int SET_BITS   = 5;
    localparam int PAGE_SHIFT = 12;
    localparam int REG_W      = 32;
    localparam int ASID_W     = 8;

    // register bit positions (fixed by software decoding)
    localparam int EN_B    = 0;
    localparam int IDXM_B  = 1;
    localparam int FLUSH_B = 2;
    localparam int CNT_LO  = 4;
    localparam int VM_B    = 8;

    typedef struct packed {
        logic single_space;
        logic idx_hash;
        logic xlat_on;
    } ctl_fields_t;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_MISS,
        EV_OTHER
    } evt_kind_t;

    // lowest-numbered way whose valid bit is clear
    function automatic logic [CNT_W-1:0] first_free(input logic [WAYS-1:0] v);
        logic [CNT_W-1:0] r;
        r = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!v[i]) r = CNT_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/tlb_ctl_reg.sv
module tlb_ctl_reg
    import tlb_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output ctl_fields_t      fields,
    output logic             flush_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            fields      <= '0;
            flush_pulse <= 1'b0;
        end else begin
            flush_pulse <= wr_en && wr_data[FLUSH_B];
            if (wr_en) begin
                fields.xlat_on      <= wr_data[EN_B];
                fields.idx_hash     <= wr_data[IDXM_B];
                fields.single_space <= wr_data[VM_B];
            end
        end
    end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr
    import tlb_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_cnt,
    input  logic             miss_evt,
    input  logic             other_evt,
    input  logic [WAYS-1:0]  set_valid,
    input  logic [CNT_W-1:0] fault_way,
    output logic [CNT_W-1:0] cnt
);
    evt_kind_t        kind;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        if (miss_evt)       kind = EV_MISS;
        else if (other_evt) kind = EV_OTHER;
        else                kind = EV_NONE;
    end

    always_comb begin
        unique case (kind)
            EV_MISS:  cnt_nxt = (&set_valid) ? cnt + 1'b1 : first_free(set_valid);
            EV_OTHER: cnt_nxt = fault_way;
            default:  cnt_nxt = wr_en ? wr_cnt : cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_nxt;
    end

    p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (miss_evt && (&set_valid)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

    p_way0_free_r8: assert property (@(posedge clk) disable iff (rst)
        (miss_evt && !set_valid[0]) |=> (cnt == '0));

    p_other_load_r9: assert property (@(posedge clk) disable iff (rst)
        (other_evt && !miss_evt) |=> (cnt == $past(fault_way)));
endmodule

// File: rtl/tlb_set_index.sv
module tlb_set_index
    import tlb_ctl_pkg::*;
(
    input  logic [REG_W-1:0]    va,
    input  logic [ASID_W-1:0]   asid,
    input  logic                hash_en,
    output logic [SET_BITS-1:0] set_idx
);
    logic [SET_BITS-1:0] mix;

    assign mix     = hash_en ? asid[SET_BITS-1:0] : '0;
    assign set_idx = va[PAGE_SHIFT +: SET_BITS] ^ mix;
endmodule

// File: rtl/tlb_ctrl_top.sv
module tlb_ctrl_top
    import tlb_ctl_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    input  logic                miss_evt,
    input  logic                other_evt,
    input  logic [WAYS-1:0]     set_valid,
    input  logic [CNT_W-1:0]    fault_way,
    input  logic [REG_W-1:0]    va,
    input  logic [ASID_W-1:0]   asid,
    output logic [SET_BITS-1:0] set_idx,
    output logic                xlat_on,
    output logic                idx_hash,
    output logic                single_space,
    output logic                flush_pulse
);
    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'(1) << EN_B) | (REG_W'(1) << IDXM_B) | (REG_W'(1) << VM_B) |
        (REG_W'((1 << CNT_W) - 1) << CNT_LO);

    ctl_fields_t      fields;
    logic [CNT_W-1:0] cnt;

    tlb_ctl_reg u_reg (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .fields(fields), .flush_pulse(flush_pulse)
    );

    tlb_repl_ctr u_ctr (
        .clk(clk), .rst(rst), .wr_en(wr_en),
        .wr_cnt(wr_data[CNT_LO +: CNT_W]),
        .miss_evt(miss_evt), .other_evt(other_evt),
        .set_valid(set_valid), .fault_way(fault_way), .cnt(cnt)
    );

    tlb_set_index u_idx (
        .va(va), .asid(asid), .hash_en(fields.idx_hash), .set_idx(set_idx)
    );

    assign xlat_on      = fields.xlat_on;
    assign idx_hash     = fields.idx_hash;
    assign single_space = fields.single_space;

    always_comb begin
        rd_data                     = '0;
        rd_data[EN_B]               = fields.xlat_on;
        rd_data[IDXM_B]             = fields.idx_hash;
        rd_data[VM_B]               = fields.single_space;
        rd_data[CNT_LO +: CNT_W]    = cnt;
    end

    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_data & ~LIVE_MASK) == '0);

    p_flush_after_wr_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_data[FLUSH_B]) |=> flush_pulse);

    p_no_stray_flush_r4: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_data[FLUSH_B]) |=> !flush_pulse);

    p_wr_fields_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (xlat_on == $past(wr_data[EN_B]) &&
                   single_space == $past(wr_data[VM_B])));
endmodule

// File: tb/sim_tlb_ctrl_top.sv
module sim_tlb_ctrl_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic        miss_evt, other_evt;
    logic [3:0]  set_valid;
    logic [1:0]  fault_way;
    logic [31:0] va;
    logic [7:0]  asid;
    logic [4:0]  set_idx;
    logic        xlat_on, idx_hash, single_space, flush_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    tlb_ctrl_top u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .miss_evt(miss_evt), .other_evt(other_evt), .set_valid(set_valid),
        .fault_way(fault_way), .va(va), .asid(asid), .set_idx(set_idx),
        .xlat_on(xlat_on), .idx_hash(idx_hash), .single_space(single_space),
        .flush_pulse(flush_pulse)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_evt(input logic m, input logic o, input logic [3:0] v, input logic [1:0] w);
        @(negedge clk);
        miss_evt = m; other_evt = o; set_valid = v; fault_way = w;
        @(negedge clk);
        miss_evt = 1'b0; other_evt = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rd_data", rd_data, 32'h0);
        chk("R1 flush", {31'h0, flush_pulse}, 32'h0);
        chk("R1 outs", {29'h0, xlat_on, idx_hash, single_space}, 32'h0);
    endtask

    task automatic t_fields;
        reg_wr(32'h0000_0103);
        chk("R2 readback", rd_data, 32'h0000_0103);
        chk("R2 outs", {29'h0, xlat_on, idx_hash, single_space}, 32'h7);
        reg_wr(32'h0000_0030);
        chk("R2 counter", rd_data, 32'h0000_0030);
        chk("R2 outs off", {29'h0, xlat_on, idx_hash, single_space}, 32'h0);
    endtask

    task automatic t_reserved;
        reg_wr(32'hFFFF_FFFF);
        chk("R3 all ones", rd_data, 32'h0000_0133);
        chk("R4 pulse on all ones", {31'h0, flush_pulse}, 32'h1);
        reg_wr(32'hFFFF_FEC8);
        chk("R3 reserved only", rd_data, 32'h0);
    endtask

    task automatic t_flush;
        reg_wr(32'h0000_0005);
        chk("R4 pulse high", {31'h0, flush_pulse}, 32'h1);
        chk("R4 bit2 reads 0", rd_data, 32'h0000_0001);
        @(negedge clk);
        chk("R4 pulse one cycle", {31'h0, flush_pulse}, 32'h0);
        reg_wr(32'h0000_0001);
        chk("R4 no pulse", {31'h0, flush_pulse}, 32'h0);
    endtask

    task automatic t_index;
        reg_wr(32'h0);
        va = 32'h0001_5000; asid = 8'h0A;
        #1 chk("R5 plain", {27'h0, set_idx}, 32'h15);
        reg_wr(32'h2);
        #1 chk("R6 hashed", {27'h0, set_idx}, 32'h1F);
        va = 32'hFFFE_3FFF; asid = 8'h23;
        #1 chk("R6 hashed zero", {27'h0, set_idx}, 32'h0);
        reg_wr(32'h0);
        #1 chk("R5 plain upper", {27'h0, set_idx}, 32'h03);
    endtask

    task automatic t_miss;
        reg_wr(32'h30);
        pulse_evt(1'b1, 1'b0, 4'hF, 2'd0);
        chk("R7 wrap 3->0", rd_data, 32'h00);
        pulse_evt(1'b1, 1'b0, 4'hF, 2'd0);
        chk("R7 0->1", rd_data, 32'h10);
        pulse_evt(1'b1, 1'b0, 4'b1011, 2'd0);
        chk("R8 way2", rd_data, 32'h20);
        pulse_evt(1'b1, 1'b0, 4'b0111, 2'd0);
        chk("R8 way3", rd_data, 32'h30);
        pulse_evt(1'b1, 1'b0, 4'b0000, 2'd0);
        chk("R8 way0", rd_data, 32'h00);
        pulse_evt(1'b1, 1'b0, 4'b1101, 2'd0);
        chk("R8 way1", rd_data, 32'h10);
    endtask

    task automatic t_other;
        pulse_evt(1'b0, 1'b1, 4'h0, 2'd2);
        chk("R9 load 2", rd_data, 32'h20);
        pulse_evt(1'b0, 1'b1, 4'hF, 2'd3);
        chk("R9 load 3", rd_data, 32'h30);
    endtask

    task automatic t_collide;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 32'h0000_0031;
        other_evt = 1'b1; fault_way = 2'd1;
        @(negedge clk);
        wr_en = 1'b0; other_evt = 1'b0;
        chk("R10 event wins counter", rd_data, 32'h0000_0011);
        pulse_evt(1'b1, 1'b1, 4'b1110, 2'd3);
        chk("R11 miss over other", rd_data, 32'h0000_0001);
    endtask

    initial begin
        rst = 1'b1; wr_en = 0; wr_data = 0; miss_evt = 0; other_evt = 0;
        set_valid = 0; fault_way = 0; va = 0; asid = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_fields();
        t_reserved();
        t_flush();
        t_index();
        t_miss();
        t_other();
        t_collide();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule